// File: doc/BRIEF.md
# Read-Capture Timing Calibration Sequencer

This block runs one calibration pass for the read path of a serial memory. On a `start` pulse it drops the memory clock to a safe rate and clears every capture adjustment. It then captures a reference block of `TLEN` bytes. If the target can be written, the block first writes a known fill pattern and uses that pattern as the reference. Otherwise it reads the test region at the safe rate and keeps what it reads.

It then switches to the target clock and walks a table of `NCAND` capture candidates in ascending order. Each candidate combines an input delay mode, an input delay count and an extra dummy length. For each candidate the block applies the three fields, reads the test block again and compares it byte for byte against the reference. The outcome is one pass bit per candidate.

While the bits arrive, the block tracks the first longest run of passing candidates. At the end it picks the middle of that run, or a fallback index when the run length is outside an accepted window. It loads the chosen fields at the target rate and pulses `done` together with the chosen index. Variable-length dummy stays disabled from `start` until `done`.

States and transitions:
- IDLE goes to SLOW on `start`.
- SLOW goes to FILL when `writable` is high, otherwise to REF.
- FILL and REF go to CLR after the last byte beat.
- CLR goes to APPLY.
- APPLY goes to TEST.
- TEST goes to JUDGE after the last byte beat.
- JUDGE goes to APPLY for the next candidate, or to FAST after the last candidate.
- FAST goes to DONE.
- DONE goes to IDLE.

Top module: `rdcal_seq`

## Requirements
- R1: After reset the block is idle with `busy`=0, `done`=0, `pass_vec`=0, `core_sel`=1, `clk_div`=`TGT_DIV`, all three capture fields 0 and `var_dummy_en`=1.
- R2: Whenever the safe rate is selected (`core_sel`=0, meaning the 80 MHz source), `clk_div` is 4 and delay mode, delay count and extra dummy are all 0. The reference phase (FILL or REF) always runs at this rate.
- R3: With `writable`=1, the block writes `TLEN` bytes from address `BASE` at the safe rate. Byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of the word 0xA5FF005A, so the bytes run 5A, 00, FF, A5, and so on. These bytes are the reference. With `writable`=0, the reference is the `TLEN` bytes read at the safe rate.
- R4: `var_dummy_en` is 0 in every cycle in which `busy` is 1.
- R5: Candidate i has delay count i mod `STEPS`, delay mode (i / `STEPS`) mod `MODES` and extra dummy i / (`STEPS`*`MODES`). Candidates are applied at the target rate in strictly ascending order. Each one reads exactly `TLEN` bytes from `BASE`.
- R6: `pass_vec[i]` is 1 only if every byte of candidate i's test read equals the reference. A mismatch in any single byte position clears the bit.
- R7: `pass_vec` is cleared before each sweep, so a later pass reports only its own results, and it does not change while the block is idle.
- R8: The chosen index is E - L/2 (integer division). L is the length of the first longest run of passing candidates and E is the last index of that run.
- R9: When L < `MIN_RUN` or L > `MAX_RUN`, the chosen index is `DEFAULT_IDX`.
- R10: `done` is a one-cycle pulse. In that cycle `core_sel`=1, `clk_div`=`TGT_DIV`, `best_idx` holds the chosen index and the capture fields are the chosen candidate's. These settings stay in place after the pulse.
- R11: A memory request (`mem_req`) holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. Each acknowledged beat moves exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration pass (idle only) |
| writable | input | 1 | Target accepts writes; reference is the fill pattern |
| mem_req | output | 1 | Byte beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Beat accepted; read byte valid |
| mem_rdata | input | 8 | Read byte |
| core_sel | output | 1 | 0 = safe 80 MHz source, 1 = target source |
| clk_div | output | DIV_W | Memory clock divider |
| dly_mode | output | MODE_W | Input delay mode |
| dly_cnt | output | CNT_W | Input delay count |
| xdummy | output | XD_W | Extra dummy cycles |
| var_dummy_en | output | 1 | Variable-length dummy permitted |
| busy | output | 1 | Pass in progress |
| done | output | 1 | High-speed settings applied (one cycle) |
| best_idx | output | IW | Chosen candidate index |
| pass_vec | output | NCAND | One pass bit per candidate |

## Verification
Clock, divider and field outputs are combinational from the state, so the bench checks them on the falling edge of the same cycle the state is entered. `done`, `best_idx`, the final fields and `pass_vec` are all sampled on the falling edge where `done` is first seen. The hold of those settings and the drop of `done` are checked one falling edge later. The memory model acknowledges one cycle after a request, with read data valid in the acknowledge cycle. Per-cycle monitors on the falling edge therefore catch rate, order and dummy-mode violations in the cycle they occur.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SLOW, ST_FILL, ST_REF, ST_CLR,
        ST_APPLY, ST_TEST, ST_JUDGE, ST_FAST, ST_DONE
    } cal_state_e;

    localparam logic [31:0] FILL_WORD = 32'hA5FF005A;
    localparam int          SAFE_DIV  = 4;

    // Byte k of the repeating fill word, least significant byte first.
    function automatic logic [7:0] fill_byte(input int k);
        return FILL_WORD[8*(k%4) +: 8];
    endfunction

endpackage

// File: rtl/rdcal_cand_map.sv
module rdcal_cand_map #(
    parameter int NCAND  = 12,
    parameter int STEPS  = 3,
    parameter int MODES  = 2,
    parameter int IW     = 4,
    parameter int MODE_W = 2,
    parameter int CNT_W  = 2,
    parameter int XD_W   = 2
) (
    input  logic [IW-1:0]     idx,
    output logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  cnt,
    output logic [XD_W-1:0]   xd
);
    localparam int GROUP = STEPS * MODES;

    // Index decomposes as xd*GROUP + mode*STEPS + cnt.
    always_comb begin
        cnt  = CNT_W'(int'(idx) % STEPS);
        mode = MODE_W'((int'(idx) / STEPS) % MODES);
        xd   = XD_W'(int'(idx) / GROUP);
    end
endmodule

// File: rtl/rdcal_run_track.sv
module rdcal_run_track #(
    parameter int NCAND       = 12,
    parameter int IW          = 4,
    parameter int MIN_RUN     = 2,
    parameter int MAX_RUN     = 6,
    parameter int DEFAULT_IDX = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          pass,
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] chosen
);
    localparam int LW = $clog2(NCAND + 1);

    logic [LW-1:0] run_q, blen_q, run_nx;
    logic [IW-1:0] bend_q;

    assign run_nx = run_q + LW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            blen_q <= '0;
            bend_q <= '0;
        end else if (clr) begin
            run_q  <= '0;
            blen_q <= '0;
            bend_q <= '0;
        end else if (step) begin
            if (pass) begin
                run_q <= run_nx;
                // strict compare keeps the earliest run of a given length
                if (run_nx > blen_q) begin
                    blen_q <= run_nx;
                    bend_q <= idx;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    always_comb begin
        if (int'(blen_q) >= MIN_RUN && int'(blen_q) <= MAX_RUN)
            chosen = IW'(int'(bend_q) - int'(blen_q) / 2);
        else
            chosen = IW'(DEFAULT_IDX);
    end
endmodule

// File: rtl/rdcal_ref_buf.sv
module rdcal_ref_buf #(
    parameter int TLEN = 8,
    parameter int BW   = 3
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [BW-1:0] rd_idx,
    input  logic [7:0]    rd_data,
    output logic          match
);
    logic [7:0] ref_q [TLEN];

    always_ff @(posedge clk) begin
        if (wr_en) ref_q[wr_idx] <= wr_data;
    end

    assign match = (ref_q[rd_idx] == rd_data);
endmodule

// File: rtl/rdcal_seq.sv
module rdcal_seq
    import rdcal_pkg::*;
#(
    parameter int NCAND       = 12,
    parameter int STEPS       = 3,
    parameter int MODES       = 2,
    parameter int MODE_W      = 2,
    parameter int CNT_W       = 2,
    parameter int XD_W        = 2,
    parameter int TLEN        = 8,
    parameter int AW          = 16,
    parameter int BASE        = 'h40,
    parameter int DIV_W       = 4,
    parameter int TGT_DIV     = 2,
    parameter int MIN_RUN     = 2,
    parameter int MAX_RUN     = 6,
    parameter int DEFAULT_IDX = 5,
    localparam int IW         = $clog2(NCAND),
    localparam int BW         = $clog2(TLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              writable,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              core_sel,
    output logic [DIV_W-1:0]  clk_div,
    output logic [MODE_W-1:0] dly_mode,
    output logic [CNT_W-1:0]  dly_cnt,
    output logic [XD_W-1:0]   xdummy,
    output logic              var_dummy_en,
    output logic              busy,
    output logic              done,
    output logic [IW-1:0]     best_idx,
    output logic [NCAND-1:0]  pass_vec
);
    cal_state_e state_q, state_nx;

    logic [BW-1:0]    bidx_q;
    logic [IW-1:0]    cand_q, best_q, chosen, fld_idx;
    logic             mis_q, have_cal_q, match;
    logic [NCAND-1:0] pass_q;
    logic             beat, last_byte, last_cand;
    logic [MODE_W-1:0] map_mode;
    logic [CNT_W-1:0]  map_cnt;
    logic [XD_W-1:0]   map_xd;
    logic             in_slow, in_sweep;

    assign beat      = mem_req && mem_ack;
    assign last_byte = (bidx_q == BW'(TLEN - 1));
    assign last_cand = (cand_q == IW'(NCAND - 1));
    assign in_slow   = (state_q == ST_SLOW) || (state_q == ST_FILL) || (state_q == ST_REF);
    assign in_sweep  = (state_q == ST_APPLY) || (state_q == ST_TEST) || (state_q == ST_JUDGE);

    rdcal_cand_map #(
        .NCAND(NCAND), .STEPS(STEPS), .MODES(MODES), .IW(IW),
        .MODE_W(MODE_W), .CNT_W(CNT_W), .XD_W(XD_W)
    ) u_map (
        .idx(fld_idx), .mode(map_mode), .cnt(map_cnt), .xd(map_xd)
    );

    rdcal_run_track #(
        .NCAND(NCAND), .IW(IW), .MIN_RUN(MIN_RUN),
        .MAX_RUN(MAX_RUN), .DEFAULT_IDX(DEFAULT_IDX)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_CLR), .step(state_q == ST_JUDGE),
        .pass(!mis_q), .idx(cand_q), .chosen(chosen)
    );

    rdcal_ref_buf #(.TLEN(TLEN), .BW(BW)) u_ref (
        .clk(clk),
        .wr_en(beat && in_slow),
        .wr_idx(bidx_q),
        .wr_data((state_q == ST_FILL) ? fill_byte(int'(bidx_q)) : mem_rdata),
        .rd_idx(bidx_q),
        .rd_data(mem_rdata),
        .match(match)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_nx = ST_SLOW;
            ST_SLOW:  state_nx = writable ? ST_FILL : ST_REF;
            ST_FILL,
            ST_REF:   if (beat && last_byte) state_nx = ST_CLR;
            ST_CLR:   state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_TEST;
            ST_TEST:  if (beat && last_byte) state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = last_cand ? ST_FAST : ST_APPLY;
            ST_FAST:  state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Sweep datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bidx_q     <= '0;
            cand_q     <= '0;
            best_q     <= '0;
            mis_q      <= 1'b0;
            have_cal_q <= 1'b0;
            pass_q     <= '0;
        end else begin
            unique case (state_q)
                ST_SLOW:  bidx_q <= '0;
                ST_FILL,
                ST_REF:   if (beat) bidx_q <= last_byte ? '0 : bidx_q + BW'(1);
                ST_CLR: begin
                    pass_q <= '0;
                    cand_q <= '0;
                end
                ST_APPLY: begin
                    bidx_q <= '0;
                    mis_q  <= 1'b0;
                end
                ST_TEST: if (beat) begin
                    bidx_q <= last_byte ? '0 : bidx_q + BW'(1);
                    if (!match) mis_q <= 1'b1;
                end
                ST_JUDGE: begin
                    pass_q[cand_q] <= !mis_q;
                    if (!last_cand) cand_q <= cand_q + IW'(1);
                end
                ST_FAST: begin
                    best_q     <= chosen;
                    have_cal_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fld_idx      = in_sweep ? cand_q : best_q;
        busy         = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done         = (state_q == ST_DONE);
        var_dummy_en = !busy;
        core_sel     = !in_slow;
        clk_div      = in_slow ? DIV_W'(SAFE_DIV) : DIV_W'(TGT_DIV);
        mem_req      = (state_q == ST_FILL) || (state_q == ST_REF) || (state_q == ST_TEST);
        mem_we       = (state_q == ST_FILL);
        mem_addr     = AW'(BASE) + AW'(bidx_q);
        mem_wdata    = mem_we ? fill_byte(int'(bidx_q)) : 8'h00;
        best_idx     = best_q;
        pass_vec     = pass_q;
        if (in_sweep || (have_cal_q && !in_slow && state_q != ST_CLR)) begin
            dly_mode = map_mode;
            dly_cnt  = map_cnt;
            xdummy   = map_xd;
        end else begin
            dly_mode = '0;
            dly_cnt  = '0;
            xdummy   = '0;
        end
    end
endmodule

// File: rtl/rdcal_seq_chk.sv
module rdcal_seq_chk #(
    parameter int NCAND   = 12,
    parameter int IW      = 4,
    parameter int AW      = 16,
    parameter int DIV_W   = 4,
    parameter int MODE_W  = 2,
    parameter int CNT_W   = 2,
    parameter int XD_W    = 2,
    parameter int TGT_DIV = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_ack,
    input logic              core_sel,
    input logic [DIV_W-1:0]  clk_div,
    input logic [MODE_W-1:0] dly_mode,
    input logic [CNT_W-1:0]  dly_cnt,
    input logic [XD_W-1:0]   xdummy,
    input logic              var_dummy_en,
    input logic              busy,
    input logic              done,
    input logic [IW-1:0]     best_idx,
    input logic [NCAND-1:0]  pass_vec
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_slow_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !core_sel |-> (clk_div == DIV_W'(4) && dly_mode == '0 && dly_cnt == '0 && xdummy == '0));

    assert_no_var_dummy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !var_dummy_en);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (core_sel && clk_div == DIV_W'(TGT_DIV)));

    assert_best_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(best_idx) < NCAND));

    assert_vec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(pass_vec));
endmodule

bind rdcal_seq rdcal_seq_chk #(
    .NCAND(NCAND), .IW(IW), .AW(AW), .DIV_W(DIV_W), .MODE_W(MODE_W),
    .CNT_W(CNT_W), .XD_W(XD_W), .TGT_DIV(TGT_DIV)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .core_sel(core_sel), .clk_div(clk_div), .dly_mode(dly_mode),
    .dly_cnt(dly_cnt), .xdummy(xdummy), .var_dummy_en(var_dummy_en),
    .busy(busy), .done(done), .best_idx(best_idx), .pass_vec(pass_vec)
);

// File: tb/test_rdcal_seq.sv
module test_rdcal_seq;
    localparam int NCAND = 12, STEPS = 3, MODES = 2, TLEN = 8, BASE = 'h40;
    localparam int TGT_DIV = 2, MIN_RUN = 2, MAX_RUN = 6, DEFAULT_IDX = 5;
    localparam int IW = $clog2(NCAND);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, writable = 1'b0;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata = 8'h00;
    logic core_sel, var_dummy_en, busy, done;
    logic [3:0] clk_div;
    logic [1:0] dly_mode, dly_cnt, xdummy;
    logic [IW-1:0] best_idx;
    logic [NCAND-1:0] pass_vec;

    always #2 clk = ~clk;

    rdcal_seq i_rdcal_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .writable(writable),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .core_sel(core_sel), .clk_div(clk_div),
        .dly_mode(dly_mode), .dly_cnt(dly_cnt), .xdummy(xdummy),
        .var_dummy_en(var_dummy_en), .busy(busy), .done(done),
        .best_idx(best_idx), .pass_vec(pass_vec)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] mem [256];
    logic [NCAND-1:0] good_mask = '0;
    int corrupt_pos = 0;
    int err_vd, err_low, err_order, beats, last_cand;

    function automatic int cand_of(input logic [1:0] m, input logic [1:0] c, input logic [1:0] x);
        return int'(x) * STEPS * MODES + int'(m) * STEPS + int'(c);
    endfunction

    function automatic logic [7:0] fill_b(input int k);
        logic [31:0] w = 32'hA5FF005A;
        return w[8*(k%4) +: 8];
    endfunction

    function automatic int exp_best(input logic [NCAND-1:0] m);
        int run = 0, bl = 0, be = 0;
        for (int i = 0; i < NCAND; i++) begin
            if (m[i]) begin
                run++;
                if (run > bl) begin bl = run; be = i; end
            end else run = 0;
        end
        if (bl >= MIN_RUN && bl <= MAX_RUN) return be - bl / 2;
        return DEFAULT_IDX;
    endfunction

    // Memory model: ack one cycle after request, bad candidates corrupt one byte.
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && !mem_ack) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else if (core_sel && !good_mask[cand_of(dly_mode, dly_cnt, xdummy)]
                     && int'(mem_addr) - BASE == corrupt_pos)
                mem_rdata <= mem[mem_addr[7:0]] ^ 8'h10;
            else
                mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // Per-cycle monitors
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && var_dummy_en) err_vd++;
            if (!core_sel && (clk_div != 4'd4 || dly_mode != 0 || dly_cnt != 0 || xdummy != 0)) err_low++;
            if (mem_req && mem_ack && !mem_we && core_sel) begin
                if (cand_of(dly_mode, dly_cnt, xdummy) < last_cand) err_order++;
                last_cand = cand_of(dly_mode, dly_cnt, xdummy);
                beats++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [NCAND-1:0] mask, input bit wr, input int cpos);
        int eb, wd;
        bit got;
        good_mask = mask;
        corrupt_pos = cpos;
        if (!wr) for (int k = 0; k < TLEN; k++) mem[BASE + k] = 8'($urandom);
        err_vd = 0; err_low = 0; err_order = 0; beats = 0; last_cand = 0;
        @(negedge clk);
        writable = wr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wd = 0;
        got = 1'b0;
        while (!got && wd < 5000) begin
            if (done) got = 1'b1;
            else begin @(negedge clk); wd++; end
        end
        if (!got) begin
            chk(1'b0, "watchdog", wd, 0);
            return;
        end
        eb = exp_best(mask);
        chk(pass_vec == mask, "R6 R7 pass_vec", int'(pass_vec), int'(mask));
        chk(int'(best_idx) == eb, "R8 R9 best_idx", int'(best_idx), eb);
        chk(cand_of(dly_mode, dly_cnt, xdummy) == eb, "R10 R5 fields", cand_of(dly_mode, dly_cnt, xdummy), eb);
        chk(core_sel && clk_div == 4'(TGT_DIV), "R10 rate", int'(clk_div), TGT_DIV);
        chk(beats == NCAND * TLEN, "R5 R11 beats", beats, NCAND * TLEN);
        chk(err_order == 0, "R5 order", err_order, 0);
        chk(err_vd == 0, "R4 var dummy", err_vd, 0);
        chk(err_low == 0, "R2 safe rate", err_low, 0);
        if (wr) for (int k = 0; k < TLEN; k++)
            chk(mem[BASE + k] == fill_b(k), "R3 fill", int'(mem[BASE + k]), int'(fill_b(k)));
        @(negedge clk);
        chk(!done && cand_of(dly_mode, dly_cnt, xdummy) == eb && !busy, "R10 hold",
            cand_of(dly_mode, dly_cnt, xdummy), eb);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int k = 0; k < 256; k++) mem[k] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && pass_vec == '0 && var_dummy_en, "R1 idle", int'(pass_vec), 0);
        chk(core_sel && clk_div == 4'(TGT_DIV) && dly_mode == 0 && dly_cnt == 0 && xdummy == 0,
            "R1 rate", int'(clk_div), TGT_DIV);
        // directed cases
        run_one(12'h000, 1'b0, 0);          // R9 no pass
        run_one(12'hFFF, 1'b1, TLEN - 1);   // R9 too long, R3 fill
        run_one(12'h080, 1'b0, 3);          // R9 single pass
        run_one(12'h00E, 1'b1, 0);          // R8 len 3 -> 2
        run_one(12'h033, 1'b0, TLEN - 1);   // R8 tie, first run -> 0
        run_one(12'hF00, 1'b0, 5);          // R8 run at table end -> 9
        run_one(12'h0FC, 1'b1, 2);          // R8 len 6 -> 4
        run_one(12'h0FE, 1'b0, 1);          // R9 len 7 -> default
        // random cases
        for (int n = 0; n < 20; n++)
            run_one(NCAND'($urandom), 1'($urandom), int'($urandom % TLEN));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule